// File: doc/BRIEF.md
# Interleaved Partial-Distance Accumulator

This block computes the running partial Euclidean distance of a depth-first tree search: each accepted input adds the squared magnitude of the complex error `b - r*s` to the distance already held for its stream. Here `r` is a real, non-negative diagonal gain, and `b` and `s` are complex fixed-point values. The recursion `d_new = d_prev + |b - r*s|^2` is broken by pipeline registers. The block therefore serves `NUM_SLOTS` independent streams in strict round-robin, and each stream sees exactly the result the unpipelined recursion would give.

A free-running slot counter names the stream that owns the current cycle. The source feeds that stream's data when it has some, and otherwise leaves a bubble. Every piece of state that lives across iterations is held once per stream and addressed by the slot tag:

- the accumulated distance;
- a three-state status (idle, running, saturated);
- a double-buffered table of diagonal gains. The source fills the shadow half while the active half is in use, and then swaps the two halves when a new problem starts.

Each stream's status machine has three states:

- **ST_IDLE**: the stream has no distance yet.
- **ST_RUN**: the stream holds a valid, unsaturated sum.
- **ST_SAT**: the sum has reached the ceiling.

It has four transitions:

- **IDLE→RUN / IDLE→SAT**: the first valid input arrives.
- **RUN→SAT**: the sum reaches the ceiling.
- **SAT→RUN**: a valid input with clear yields a sum below the ceiling.
- **any→IDLE**: a clear arrives without a valid input.

Top module: `ipd_unit`

## Requirements
- R1: `in_slot` is 0 after reset. It advances by one on every clock, wrapping from `NUM_SLOTS-1` to 0, whether or not inputs are valid.
- R2: An input accepted while `in_slot` = n produces its result exactly `NUM_SLOTS` cycles later, with `out_valid` = 1 and `out_slot` = n. `out_slot` then equals `in_slot`.
- R3: `out_dist` = d_prev + (b_re - r*s_re)^2 + (b_im - r*s_im)^2, where r is the entry at index `in_level` in the active gain half of that stream. d_prev is that stream's previous result, and streams never affect one another.
- R4: `in_clear` with `in_valid` makes d_prev zero for that input. `in_clear` without `in_valid` resets only the owning stream to idle with distance zero, and produces no output.
- R5: A cycle without `in_valid` produces `out_valid` = 0 with `out_dist`, `out_slot` and `out_sat` all zero `NUM_SLOTS` cycles later.
- R6: A sum that reaches or exceeds 2^`W_D`-1 gives `out_dist` = 2^`W_D`-1 and `out_sat` = 1. The stream then stays at that value for later inputs until a clear.
- R7: `ld_en` writes `ld_value` into the shadow half of stream `ld_slot` at index `ld_level`, and it does not change results until a swap. `in_swap` toggles the active half of the owning stream, and the toggle already applies to that same cycle's input.
- R8: When a load and a swap address the same stream in one cycle, the load lands in the half being retired, which is the half inactive after the swap.
- R9: After reset every gain entry is zero, half 0 is active for every stream, and every stream is idle with distance zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input data for the owning stream is present |
| in_clear | input | 1 | Restart the owning stream's distance at zero |
| in_swap | input | 1 | Toggle the owning stream's active gain half |
| in_level | input | W_LVL (2) | Gain table index for this input |
| in_b_re | input | W_B (8) | Real part of b, signed |
| in_b_im | input | W_B (8) | Imaginary part of b, signed |
| in_s_re | input | W_S (4) | Real part of s, signed |
| in_s_im | input | W_S (4) | Imaginary part of s, signed |
| ld_en | input | 1 | Write a gain entry into a shadow half |
| ld_slot | input | W_SLOT (2) | Stream whose shadow half is written |
| ld_level | input | W_LVL (2) | Gain index written |
| ld_value | input | W_R (6) | Unsigned gain value |
| in_slot | output | W_SLOT (2) | Stream owning the current input cycle |
| out_valid | output | 1 | A result is present |
| out_slot | output | W_SLOT (2) | Stream tag of the result |
| out_dist | output | W_D (16) | Accumulated distance, saturating |
| out_sat | output | 1 | The result is at the ceiling |

## Verification
Two pairs of functions can land in the same cycle.

- **Gain load and swap on the same stream.** The bench, at a stream's own slot, issues a swap together with a load to that stream while also feeding a valid input. It then checks two things. First, that input must use the entry that sat in the newly active half before the load. Second, the loaded value must show up only after the following swap.
- **Clear on a saturated stream.** The bench first drives a stream into saturation. It then sends a clear together with a valid input, and expects an unsaturated sum built from the new increment alone.

A clear without valid is placed in one stream's slot between valid inputs of its neighbours. The bench checks that only that stream restarts from zero.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    // Per-stream status of the running distance
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAT  = 2'd2
    } strm_state_e;

endpackage

// File: rtl/ipd_slot_ctr.sv
module ipd_slot_ctr #(
    parameter int NUM_SLOTS = 3,
    parameter int W_SLOT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [W_SLOT-1:0] slot
);
    localparam logic [W_SLOT-1:0] LAST = W_SLOT'(NUM_SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end
endmodule

// File: rtl/ipd_coef_bank.sv
module ipd_coef_bank #(
    parameter int NUM_SLOTS  = 3,
    parameter int NUM_LEVELS = 4,
    parameter int W_R        = 6,
    parameter int W_SLOT     = 2,
    parameter int W_LVL      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W_SLOT-1:0] rd_slot,
    input  logic [W_LVL-1:0]  rd_level,
    input  logic              swap,
    input  logic              ld_en,
    input  logic [W_SLOT-1:0] ld_slot,
    input  logic [W_LVL-1:0]  ld_level,
    input  logic [W_R-1:0]    ld_value,
    output logic [W_R-1:0]    rd_value
);
    logic [W_R-1:0]       slot_rd [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] sel_nxt;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic           sel_q;
        logic [W_R-1:0] mem_q [2][NUM_LEVELS];

        // the owning stream's swap takes effect for this cycle's read
        assign sel_nxt[g] = sel_q ^ (swap && (rd_slot == W_SLOT'(g)));
        assign slot_rd[g] = mem_q[sel_nxt[g]][rd_level];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q <= 1'b0;
                for (int h = 0; h < 2; h++)
                    for (int l = 0; l < NUM_LEVELS; l++)
                        mem_q[h][l] <= '0;
            end else begin
                sel_q <= sel_nxt[g];
                // loads go to the half that is inactive after any swap
                if (ld_en && (ld_slot == W_SLOT'(g)))
                    mem_q[~sel_nxt[g]][ld_level] <= ld_value;
            end
        end
    end

    assign rd_value = slot_rd[rd_slot];
endmodule

// File: rtl/ipd_metric.sv
module ipd_metric #(
    parameter int NUM_SLOTS = 3,
    parameter int W_B       = 8,
    parameter int W_R       = 6,
    parameter int W_S       = 4,
    parameter int W_SLOT    = 2,
    parameter int W_P       = W_R + W_S + 1,
    parameter int W_E       = ((W_B > W_P) ? W_B : W_P) + 1,
    parameter int W_Q       = 2 * W_E + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_clear,
    input  logic [W_SLOT-1:0]     in_slot,
    input  logic [W_R-1:0]        r_val,
    input  logic signed [W_B-1:0] b_re,
    input  logic signed [W_B-1:0] b_im,
    input  logic signed [W_S-1:0] s_re,
    input  logic signed [W_S-1:0] s_im,
    output logic                  out_valid,
    output logic                  out_clear,
    output logic [W_SLOT-1:0]     out_slot,
    output logic [W_Q-1:0]        out_sq
);
    localparam int DLY   = NUM_SLOTS - 3;
    localparam int W_BUN = 2 + W_SLOT + W_Q;

    // stage 1: complex error b - r*s
    logic signed [W_P-1:0] r_ext, sre_ext, sim_ext, prod_re, prod_im;
    logic signed [W_E-1:0] e_re, e_im;

    assign r_ext   = {{W_S{1'b0}}, r_val};
    assign sre_ext = {{(W_R + 1){s_re[W_S-1]}}, s_re};
    assign sim_ext = {{(W_R + 1){s_im[W_S-1]}}, s_im};
    assign prod_re = r_ext * sre_ext;
    assign prod_im = r_ext * sim_ext;
    assign e_re = {{(W_E - W_B){b_re[W_B-1]}}, b_re} - {{(W_E - W_P){prod_re[W_P-1]}}, prod_re};
    assign e_im = {{(W_E - W_B){b_im[W_B-1]}}, b_im} - {{(W_E - W_P){prod_im[W_P-1]}}, prod_im};

    logic                  v1, c1;
    logic [W_SLOT-1:0]     slot1;
    logic signed [W_E-1:0] e_re1, e_im1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; c1 <= 1'b0; slot1 <= '0; e_re1 <= '0; e_im1 <= '0;
        end else begin
            v1    <= in_valid;
            c1    <= in_clear;
            slot1 <= in_slot;
            e_re1 <= in_valid ? e_re : '0;
            e_im1 <= in_valid ? e_im : '0;
        end
    end

    // stage 2: squared magnitude
    logic signed [2*W_E-1:0] x_re, x_im, sq_re, sq_im;
    logic [W_Q-1:0]          q_sum;

    assign x_re  = {{W_E{e_re1[W_E-1]}}, e_re1};
    assign x_im  = {{W_E{e_im1[W_E-1]}}, e_im1};
    assign sq_re = x_re * x_re;
    assign sq_im = x_im * x_im;
    assign q_sum = {1'b0, sq_re} + {1'b0, sq_im};

    logic [W_BUN-1:0] bun2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bun2 <= '0;
        else
            bun2 <= {v1, c1, slot1, q_sum};
    end

    // padding so that the whole loop holds exactly NUM_SLOTS registers
    logic [W_BUN-1:0] bun_out;

    if (DLY == 0) begin : g_nodly
        assign bun_out = bun2;
    end else begin : g_dly
        logic [W_BUN-1:0] pipe_q [DLY];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DLY; i++) pipe_q[i] <= '0;
            end else begin
                pipe_q[0] <= bun2;
                for (int i = 1; i < DLY; i++) pipe_q[i] <= pipe_q[i-1];
            end
        end
        assign bun_out = pipe_q[DLY-1];
    end

    assign {out_valid, out_clear, out_slot, out_sq} = bun_out;
endmodule

// File: rtl/ipd_accum.sv
module ipd_accum
    import ipd_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int W_Q       = 25,
    parameter int W_D       = 16,
    parameter int W_SLOT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_clear,
    input  logic [W_SLOT-1:0] in_slot,
    input  logic [W_Q-1:0]    in_sq,
    output logic              out_valid,
    output logic [W_SLOT-1:0] out_slot,
    output logic [W_D-1:0]    out_dist,
    output logic              out_sat
);
    localparam int           W_SUM = ((W_Q > W_D) ? W_Q : W_D) + 1;
    localparam logic [W_D-1:0] D_MAX = {W_D{1'b1}};

    strm_state_e        st_q  [NUM_SLOTS];
    logic [W_D-1:0]     acc_q [NUM_SLOTS];

    strm_state_e        cur_st, nxt_st;
    logic [W_D-1:0]     base, nxt_dist;
    logic [W_SUM-1:0]   sum;
    logic               ovf, upd;

    assign cur_st = st_q[in_slot];
    assign base   = (in_clear || (cur_st == ST_IDLE)) ? '0 : acc_q[in_slot];
    assign sum    = W_SUM'(base) + W_SUM'(in_sq);
    assign ovf    = (sum >= W_SUM'(D_MAX));
    assign upd    = in_valid || in_clear;

    // next state and distance of the stream owning this cycle
    always_comb begin
        nxt_st   = cur_st;
        nxt_dist = acc_q[in_slot];
        if (in_valid) begin
            nxt_dist = ovf ? D_MAX : sum[W_D-1:0];
            unique case (cur_st)
                ST_IDLE, ST_RUN: nxt_st = ovf ? ST_SAT : ST_RUN;
                ST_SAT:          nxt_st = (in_clear && !ovf) ? ST_RUN : ST_SAT;
                default:         nxt_st = ST_IDLE;
            endcase
        end else if (in_clear) begin
            nxt_st   = ST_IDLE;
            nxt_dist = '0;
        end
    end

    // state register: one copy per stream, addressed by slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                st_q[i]  <= ST_IDLE;
                acc_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (upd && (in_slot == W_SLOT'(i))) begin
                    st_q[i]  <= nxt_st;
                    acc_q[i] <= nxt_dist;
                end
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_dist  <= '0;
            out_sat   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_slot  <= in_valid ? in_slot : '0;
            out_dist  <= in_valid ? nxt_dist : '0;
            out_sat   <= in_valid && (nxt_st == ST_SAT);
        end
    end
endmodule

// File: rtl/ipd_unit.sv
module ipd_unit #(
    parameter int NUM_SLOTS  = 3,
    parameter int NUM_LEVELS = 4,
    parameter int W_B        = 8,
    parameter int W_R        = 6,
    parameter int W_S        = 4,
    parameter int W_D        = 16,
    parameter int W_SLOT     = $clog2(NUM_SLOTS),
    parameter int W_LVL      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_clear,
    input  logic                  in_swap,
    input  logic [W_LVL-1:0]      in_level,
    input  logic signed [W_B-1:0] in_b_re,
    input  logic signed [W_B-1:0] in_b_im,
    input  logic signed [W_S-1:0] in_s_re,
    input  logic signed [W_S-1:0] in_s_im,
    input  logic                  ld_en,
    input  logic [W_SLOT-1:0]     ld_slot,
    input  logic [W_LVL-1:0]      ld_level,
    input  logic [W_R-1:0]        ld_value,
    output logic [W_SLOT-1:0]     in_slot,
    output logic                  out_valid,
    output logic [W_SLOT-1:0]     out_slot,
    output logic [W_D-1:0]        out_dist,
    output logic                  out_sat
);
    localparam int W_P = W_R + W_S + 1;
    localparam int W_E = ((W_B > W_P) ? W_B : W_P) + 1;
    localparam int W_Q = 2 * W_E + 1;

    logic [W_SLOT-1:0] slot_cur;
    logic [W_R-1:0]    r_val;
    logic              m_valid, m_clear;
    logic [W_SLOT-1:0] m_slot;
    logic [W_Q-1:0]    m_sq;

    ipd_slot_ctr #(.NUM_SLOTS(NUM_SLOTS), .W_SLOT(W_SLOT)) u_ctr (
        .clk(clk), .rst_n(rst_n), .slot(slot_cur)
    );

    ipd_coef_bank #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_LEVELS(NUM_LEVELS), .W_R(W_R),
        .W_SLOT(W_SLOT), .W_LVL(W_LVL)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_slot(slot_cur), .rd_level(in_level), .swap(in_swap),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_level(ld_level), .ld_value(ld_value),
        .rd_value(r_val)
    );

    ipd_metric #(
        .NUM_SLOTS(NUM_SLOTS), .W_B(W_B), .W_R(W_R), .W_S(W_S), .W_SLOT(W_SLOT),
        .W_P(W_P), .W_E(W_E), .W_Q(W_Q)
    ) u_metric (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_clear(in_clear), .in_slot(slot_cur), .r_val(r_val),
        .b_re(in_b_re), .b_im(in_b_im), .s_re(in_s_re), .s_im(in_s_im),
        .out_valid(m_valid), .out_clear(m_clear), .out_slot(m_slot), .out_sq(m_sq)
    );

    ipd_accum #(.NUM_SLOTS(NUM_SLOTS), .W_Q(W_Q), .W_D(W_D), .W_SLOT(W_SLOT)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .in_valid(m_valid), .in_clear(m_clear), .in_slot(m_slot), .in_sq(m_sq),
        .out_valid(out_valid), .out_slot(out_slot), .out_dist(out_dist), .out_sat(out_sat)
    );

    assign in_slot = slot_cur;
endmodule

// File: rtl/ipd_unit_chk.sv
module ipd_unit_chk #(
    parameter int NUM_SLOTS = 3,
    parameter int W_D       = 16,
    parameter int W_SLOT    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W_SLOT-1:0] in_slot,
    input logic              out_valid,
    input logic [W_SLOT-1:0] out_slot,
    input logic [W_D-1:0]    out_dist,
    input logic              out_sat
);
    localparam logic [W_SLOT-1:0] LAST  = W_SLOT'(NUM_SLOTS - 1);
    localparam logic [W_D-1:0]    D_MAX = {W_D{1'b1}};

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot <= LAST); // R1

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_slot == (($past(in_slot) == LAST) ? '0 : $past(in_slot) + 1'b1)); // R1

    AST_OUT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_slot == in_slot); // R2

    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_dist == '0 && !out_sat && out_slot == '0)); // R5

    AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> (out_valid && out_dist == D_MAX)); // R6

    AST_MAX_IS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sat) |-> out_dist != D_MAX); // R6
endmodule

bind ipd_unit ipd_unit_chk #(.NUM_SLOTS(NUM_SLOTS), .W_D(W_D), .W_SLOT(W_SLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_slot(in_slot), .out_valid(out_valid),
    .out_slot(out_slot), .out_dist(out_dist), .out_sat(out_sat)
);

// File: tb/ipd_unit_tb.sv
module ipd_unit_tb;
    localparam int P = 3, LV = 4, WB = 8, WR = 6, WS = 4, WD = 16, WSL = 2, WLV = 2;
    localparam int DMAX = 65535;
    localparam int NEXP = 4096;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_clear = 0, in_swap = 0, ld_en = 0;
    logic [WLV-1:0] in_level = '0, ld_level = '0;
    logic signed [WB-1:0] in_b_re = '0, in_b_im = '0;
    logic signed [WS-1:0] in_s_re = '0, in_s_im = '0;
    logic [WSL-1:0] ld_slot = '0;
    logic [WR-1:0] ld_value = '0;
    logic [WSL-1:0] in_slot, out_slot;
    logic out_valid, out_sat;
    logic [WD-1:0] out_dist;

    always #10 clk = ~clk;

    ipd_unit #(.NUM_SLOTS(P), .NUM_LEVELS(LV), .W_B(WB), .W_R(WR), .W_S(WS), .W_D(WD)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear), .in_swap(in_swap),
        .in_level(in_level), .in_b_re(in_b_re), .in_b_im(in_b_im), .in_s_re(in_s_re),
        .in_s_im(in_s_im), .ld_en(ld_en), .ld_slot(ld_slot), .ld_level(ld_level),
        .ld_value(ld_value), .in_slot(in_slot), .out_valid(out_valid), .out_slot(out_slot),
        .out_dist(out_dist), .out_sat(out_sat)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    int bankm [P][2][LV];
    int selm [P];
    int accm [P];
    bit satm [P];
    bit exp_v [NEXP];
    int exp_d [NEXP];
    int exp_s [NEXP];
    bit exp_sat [NEXP];
    string exp_tag [NEXP];
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 8);
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
        end
    endtask

    // one input cycle: check outputs, drive inputs, update model, advance
    task automatic step(input bit v, input bit clr, input bit swp, input int lvl,
                        input int bre, input int bim, input int sre, input int sim,
                        input bit lden, input int lds, input int ldl, input int ldv,
                        input string tag);
        int slot, r, er, ei, base, sum;
        chk("R1 in_slot", int'(in_slot), cyc % P);
        chk({exp_v[cyc] ? "R2" : "R5", " out_valid"}, int'(out_valid), int'(exp_v[cyc]));
        if (exp_v[cyc]) begin
            chk("R2 out_slot", int'(out_slot), exp_s[cyc]);
            chk({exp_tag[cyc], " out_dist"}, int'(out_dist), exp_d[cyc]);
            chk("R6 out_sat", int'(out_sat), int'(exp_sat[cyc]));
        end else begin
            chk("R5 out_dist", int'(out_dist), 0);
            chk("R5 out_sat", int'(out_sat), 0);
        end
        in_valid = v; in_clear = clr; in_swap = swp; in_level = WLV'(lvl);
        in_b_re = WB'(bre); in_b_im = WB'(bim); in_s_re = WS'(sre); in_s_im = WS'(sim);
        ld_en = lden; ld_slot = WSL'(lds); ld_level = WLV'(ldl); ld_value = WR'(ldv);
        slot = cyc % P;
        if (swp) selm[slot] ^= 1;
        if (v) begin
            r = bankm[slot][selm[slot]][lvl];
            er = bre - r * sre;
            ei = bim - r * sim;
            if (satm[slot] && !clr) begin
                exp_d[cyc+P] = DMAX;
            end else begin
                base = clr ? 0 : accm[slot];
                sum = base + er * er + ei * ei;
                if (sum >= DMAX) begin
                    satm[slot] = 1; accm[slot] = DMAX;
                end else begin
                    satm[slot] = 0; accm[slot] = sum;
                end
                exp_d[cyc+P] = accm[slot];
            end
            exp_v[cyc+P] = 1; exp_s[cyc+P] = slot; exp_sat[cyc+P] = satm[slot];
            exp_tag[cyc+P] = satm[slot] ? "R6" : tag;
        end else if (clr) begin
            accm[slot] = 0; satm[slot] = 0;
        end
        if (lden) bankm[lds][selm[lds] ^ 1][ldl] = ldv;   // R7 R8: shadow after swap
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < NEXP; i++) exp_v[i] = 0;
        for (int s = 0; s < P; s++) begin
            selm[s] = 0; accm[s] = 0; satm[s] = 0;
            for (int h = 0; h < 2; h++) for (int l = 0; l < LV; l++) bankm[s][h][l] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R9 reset out_valid", int'(out_valid), 0);
        chk("R9 reset out_dist", int'(out_dist), 0);
        chk("R9 reset in_slot", int'(in_slot), 0);
        rst_n = 1'b1;

        // R9: zero gains, idle streams
        for (int i = 0; i < 9; i++)
            step(1, i < 3, 0, i % LV, i - 4, 3 - i, 2, -1, 0, 0, 0, 0, "R9");

        // R7: fill shadow halves while inputs still use the zero half
        for (int s = 0; s < P; s++)
            for (int l = 0; l < LV; l++)
                step(1, 1, 0, l, 5, -6, 1, 1, 1, s, l, (s * 3 + l) % 8 + 1, "R7");
        for (int i = 0; i < P; i++)
            step(1, 1, 1, 2, 7, 4, -3, 2, 0, 0, 0, 0, "R7");

        // R3: exhaustive symbol sweep, clear every input
        for (int sr = -8; sr < 8; sr++)
            for (int si = -8; si < 8; si++)
                step(1, 1, 0, (sr + si + 16) % LV, 13, -11, sr, si, 0, 0, 0, 0, "R3");

        // R3 R5 R7: accumulation with bubbles and shadow loads
        for (int i = 0; i < 600; i++) begin
            int a, b2;
            a = rnd(); b2 = rnd();
            step((a % 4) != 0, (a % 8) == 1, 0, (a >> 4) % LV,
                 (b2 % 32) - 16, ((b2 >> 6) % 32) - 16, ((b2 >> 12) % 8) - 4,
                 ((b2 >> 16) % 8) - 4, ((a >> 8) % 4) == 0, (a >> 10) % P,
                 (a >> 12) % LV, 40 + (a >> 14) % 20, "R3");
        end

        // R4: clear without valid hits only stream 1
        for (int i = 0; i < P; i++) step(1, 1, 0, 0, 2, 1, 0, 0, 0, 0, 0, 0, "R4");
        for (int i = 0; i < P; i++) step(1, 0, 0, 1, 3, -2, 0, 0, 0, 0, 0, 0, "R4");
        for (int i = 0; i < P; i++) begin
            if (cyc % P == 1) step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
            else              step(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R4");
        end
        for (int i = 0; i < P; i++) step(1, 0, 0, 2, 4, 4, 0, 0, 0, 0, 0, 0, "R4");

        // R6: saturate, stay saturated, then clear with valid
        for (int i = 0; i < 2 * P; i++) step(1, i < P, 0, 0, 127, 127, -8, -8, 0, 0, 0, 0, "R6");
        for (int i = 0; i < P; i++) step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < P; i++) step(1, 1, 0, 1, 3, 2, 1, 0, 0, 0, 0, 0, "R6");

        // R8: load and swap to the same stream in one cycle
        for (int i = 0; i < P; i++)
            step(1, 1, 1, 0, 5, 1, 1, 0, 1, cyc % P, 0, 9 + cyc % P, "R8");
        for (int i = 0; i < P; i++)
            step(1, 1, 1, 0, 5, 1, 1, 0, 0, 0, 0, 0, "R8");

        // drain
        for (int i = 0; i < 2 * P; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule